// File: doc/BRIEF.md
# Legacy Interrupt Vector Dispatcher

This block sits between sixteen level-sensitive legacy peripheral interrupt lines and a processor that takes interrupts as numbered vectors out of a 64-entry vector space. A fixed, sparse table gives each of five lines its own vector number. Every other line is never looked at. The block holds a single delivery slot. When a mapped line goes high while the slot is free, the block claims the slot, raises its request and loads three 64-bit data words that software reads to find out which vector fired.

The slot is an interlock, not a queue. A line that rises while a delivery is outstanding is dropped and is not remembered. The slot frees in one of two ways: the line that claimed it goes low, or software pulses the acknowledge input for one cycle. Once the slot is free, the vector output and the data words keep their last values until the next accepted raise.

All inputs are synchronous to the clock. Every result is registered and appears one clock after the edge that causes it.

Top module: `irq_vec_dispatch`

## Requirements
- R1: The fixed map sends legacy line 1 to vector 0x29, line 4 to 0x2b, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2a.
- R2: A line that has no map entry (lines 0, 2, 3, 5, 8–11, 13–15) has no effect at any level. The request, status, vector and data words stay as they were.
- R3: `vec_o` is 6 bits wide, enough to index the 64-entry vector space. It shows the vector of the most recently accepted raise, and 0 after reset.
- R4: A rising mapped line with the slot free produces, one clock later, `irq_req_o` = 1 and `status_o` = 0x20. The busy flag is bit 5 of `status_o`, and every other status bit is 0.
- R5: An accepted raise loads `word0_o` with 0x1F in bits 10:6 and the vector number in bits 5:0, with all other bits 0. The same raise sets `word1_o` and `word2_o` to 0.
- R6: A raise that arrives while busy is set is dropped. Vector, words and busy are unchanged, and the raise is not delivered later, even if its line is still high when the slot frees.
- R7: The claiming line going low while busy clears busy and the request one clock later. Another mapped line going low does not.
- R8: When several mapped lines rise in the same cycle with the slot free, the lowest line number is delivered and the others are dropped.
- R9: A one-cycle `sw_ack_i` while busy clears busy and the request one clock later and leaves the vector and words unchanged. With the slot free, the acknowledge has no effect, and a raise in that same cycle is accepted.
- R10: A synchronous active-high reset clears busy, request, vector and all three words to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_irq_i | input | 16 | Level-sensitive legacy interrupt lines |
| sw_ack_i | input | 1 | One-cycle software acknowledge, frees the slot |
| irq_req_o | output | 1 | Vector interrupt request to the processor |
| vec_o | output | 6 | Vector number of the current or last delivery |
| status_o | output | 8 | Status byte, bit 5 = busy |
| word0_o | output | 64 | Data word 0: 0x1F tag above the vector number |
| word1_o | output | 64 | Data word 1, cleared on each delivery |
| word2_o | output | 64 | Data word 2, cleared on each delivery |

## Verification
Each result (request, status, vector and the three words) is due exactly one clock after the rising edge that samples the causing line change or acknowledge. Edge detection and slot update happen in the same registered stage, so no result takes longer. The bench changes inputs on the falling edge, lets one rising edge pass, and compares every output on the next falling edge, before it drives the next stimulus. Dropped raises and non-owner falls are checked in the cycle right after they occur, when a wrong update would already show.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  // One entry of the fixed legacy-line to vector table
  typedef struct packed {
    logic       hit;
    logic [5:0] vec;
  } ivd_map_t;

  // Constant tag placed above the vector number in data word 0
  localparam logic [4:0] IVD_TAG     = 5'h1F;
  localparam int         IVD_TAG_LSB = 6;
  localparam int         IVD_TAG_W   = 5;

  // Sparse map (R1); any line not listed yields hit = 0 (R2)
  function automatic ivd_map_t map_line(input int unsigned ln);
    ivd_map_t m;
    m = '0;
    case (ln)
      1:  m = '{hit: 1'b1, vec: 6'h29};
      4:  m = '{hit: 1'b1, vec: 6'h2b};
      6:  m = '{hit: 1'b1, vec: 6'h27};
      7:  m = '{hit: 1'b1, vec: 6'h22};
      12: m = '{hit: 1'b1, vec: 6'h2a};
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ivd_edge.sv
module ivd_edge
  import ivd_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);

  // Only mapped lines get an edge detector; others are tied off (R2)
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam ivd_map_t ENTRY = map_line(i);
    if (ENTRY.hit) begin : g_mapped
      logic lvl_q;
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lines_i[i];
      end
      assign rise_o[i] =  lines_i[i] & ~lvl_q;
      assign fall_o[i] = ~lines_i[i] &  lvl_q;
    end else begin : g_unmapped
      logic unused_lvl;
      assign unused_lvl = lines_i[i];
      assign rise_o[i]  = 1'b0;
      assign fall_o[i]  = 1'b0;
    end
  end

endmodule

// File: rtl/ivd_pick.sv
module ivd_pick #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);

  // Lowest line number wins (R8)
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assert_pick_valid_R8: assert property (@(posedge clk) disable iff (rst)
    any_o |-> req_i[idx_o]);

  assert_pick_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    any_o |-> ((req_i << (NUM_LINES - int'(idx_o))) == '0));

endmodule

// File: rtl/ivd_slot.sv
module ivd_slot
  import ivd_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int VEC_W     = 6,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise_any_i,
  input  logic [IDX_W-1:0]     rise_idx_i,
  input  logic [NUM_LINES-1:0] fall_i,
  input  logic                 sw_ack_i,
  output logic                 busy_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [DATA_W-1:0]    word0_o,
  output logic [DATA_W-1:0]    word1_o,
  output logic [DATA_W-1:0]    word2_o
);

  logic              busy_q;
  logic [IDX_W-1:0]  owner_q;
  logic [VEC_W-1:0]  vec_q;
  logic [DATA_W-1:0] w0_q, w1_q, w2_q;

  ivd_map_t          sel_map;
  logic [VEC_W-1:0]  new_vec;
  logic [DATA_W-1:0] new_w0;
  logic              release_now;

  always_comb begin
    sel_map = map_line(int'(rise_idx_i));
    new_vec = VEC_W'(sel_map.vec);
    new_w0  = '0;
    new_w0[VEC_W-1:0] = new_vec;
    new_w0[IVD_TAG_LSB +: IVD_TAG_W] = IVD_TAG;
  end

  // Owner fall (R7) or software acknowledge (R9) frees the slot
  assign release_now = sw_ack_i | fall_i[owner_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      vec_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else if (busy_q) begin
      // Raises arriving now are dropped (R6)
      if (release_now) busy_q <= 1'b0;
    end else if (rise_any_i) begin
      busy_q  <= 1'b1;
      owner_q <= rise_idx_i;
      vec_q   <= new_vec;
      w0_q    <= new_w0;
      w1_q    <= '0;
      w2_q    <= '0;
    end
  end

  assign busy_o  = busy_q;
  assign vec_o   = vec_q;
  assign word0_o = w0_q;
  assign word1_o = w1_q;
  assign word2_o = w2_q;

  assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && rise_any_i) |=> busy_q);

  assert_word0_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && rise_any_i) |=> (w0_q[VEC_W-1:0] == $past(new_vec)));

  assert_clear_words_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (w1_q == '0 && w2_q == '0));

  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(vec_q) && $stable(w0_q)));

  assert_owner_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && fall_i[owner_q]) |=> !busy_q);

  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && sw_ack_i) |=> (!busy_q && $stable(w0_q)));

endmodule

// File: rtl/irq_vec_dispatch.sv
module irq_vec_dispatch #(
  parameter int NUM_LINES = 16,
  parameter int VEC_COUNT = 64,
  parameter int DATA_W    = 64,
  parameter int STAT_W    = 8,
  parameter int BUSY_BIT  = 5,
  localparam int VEC_W    = $clog2(VEC_COUNT),
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] legacy_irq_i,
  input  logic                 sw_ack_i,
  output logic                 irq_req_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [STAT_W-1:0]    status_o,
  output logic [DATA_W-1:0]    word0_o,
  output logic [DATA_W-1:0]    word1_o,
  output logic [DATA_W-1:0]    word2_o
);

  logic [NUM_LINES-1:0] rise, fall;
  logic                 rise_any;
  logic [IDX_W-1:0]     rise_idx;
  logic                 busy;

  ivd_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .lines_i (legacy_irq_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  ivd_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req_i (rise),
    .any_o (rise_any),
    .idx_o (rise_idx)
  );

  ivd_slot #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .DATA_W    (DATA_W)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .rise_any_i (rise_any),
    .rise_idx_i (rise_idx),
    .fall_i     (fall),
    .sw_ack_i   (sw_ack_i),
    .busy_o     (busy),
    .vec_o      (vec_o),
    .word0_o    (word0_o),
    .word1_o    (word1_o),
    .word2_o    (word2_o)
  );

  always_comb begin
    status_o = '0;
    status_o[BUSY_BIT] = busy;
  end

  assign irq_req_o = busy;

  assert_status_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ($countones(status_o) == 1));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!irq_req_o && (rise == '0)) |=> !irq_req_o);

endmodule

// File: tb/sim_irq_vec_dispatch.sv
module sim_irq_vec_dispatch;

  localparam int NSTEP = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lines = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [5:0]  vec;
  logic [7:0]  status;
  logic [63:0] w0, w1, w2;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_vec_dispatch u0 (
    .clk          (clk),
    .rst          (rst),
    .legacy_irq_i (lines),
    .sw_ack_i     (ack),
    .irq_req_o    (req),
    .vec_o        (vec),
    .status_o     (status),
    .word0_o      (w0),
    .word1_o      (w1),
    .word2_o      (w2)
  );

  // Stimulus table: line pattern per step, acknowledge mask, expected request,
  // expected vector and the requirement each row exercises.
  localparam logic [15:0] T_LN [NSTEP] = '{
    16'h0002,  // 0  R4 line 1 rises -> 0x29
    16'h0012,  // 1  R6 line 4 rises while busy
    16'h0002,  // 2  R7 non-owner falls, stays busy
    16'h0012,  // 3  R6 again dropped
    16'h0010,  // 4  R7 owner falls
    16'h0010,  // 5  R6 held line not queued
    16'h0000,  // 6  R7 idle
    16'h1040,  // 7  R8 lines 6 and 12 together -> 0x27
    16'h1000,  // 8  R7 owner 6 falls
    16'h0000,  // 9  R8 idle
    16'h0080,  // 10 R1 line 7 -> 0x22
    16'h0080,  // 11 R9 ack
    16'h0080,  // 12 R9 held line does not re-raise
    16'h0000,  // 13 R9 fall after ack no effect
    16'h1000,  // 14 R1 line 12 -> 0x2a
    16'h0000,  // 15 R7 owner falls
    16'h0010,  // 16 R5 line 4 -> 0x2b
    16'h0000,  // 17 R7 owner falls
    16'hEF2D,  // 18 R2 every unmapped line high
    16'h0000   // 19 R2 unmapped lines fall
  };
  localparam logic [NSTEP-1:0] T_ACK = 20'h00800;
  localparam logic [NSTEP-1:0] T_RQ  = 20'h1448F;
  localparam logic [5:0] T_VEC [NSTEP] = '{
    6'h29, 6'h29, 6'h29, 6'h29, 6'h29, 6'h29, 6'h29,
    6'h27, 6'h27, 6'h27,
    6'h22, 6'h22, 6'h22, 6'h22,
    6'h2a, 6'h2a,
    6'h2b, 6'h2b, 6'h2b, 6'h2b
  };
  localparam int T_REQ_ID [NSTEP] = '{4, 6, 7, 6, 7, 6, 7, 8, 7, 8,
                                      1, 9, 9, 9, 1, 7, 5, 7, 2, 2};

  // R5: word 0 holds tag 0x1F in bits 10:6 and the vector in bits 5:0
  function automatic logic [63:0] exp_word0(input logic [5:0] v);
    return {53'd0, 5'h1F, v};
  endfunction

  task automatic cmp(input int rid, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rid, what, act, exp);
    end
  endtask

  // Checks all outputs; vector check is R3, status check is R4, words R5
  task automatic check_all(input int rid, input logic e_req,
                           input logic [5:0] e_vec, input logic [63:0] e_w0);
    cmp(rid, "irq_req", {63'd0, req}, {63'd0, e_req});
    cmp(rid, "status",  {56'd0, status}, e_req ? 64'h20 : 64'h0);
    cmp(rid, "vector",  {58'd0, vec}, {58'd0, e_vec});
    cmp(rid, "word0",   w0, e_w0);
    cmp(rid, "word1",   w1, 64'd0);
    cmp(rid, "word2",   w2, 64'd0);
  endtask

  // Drive on the falling edge, result is due after the next rising edge
  task automatic step(input logic [15:0] ln, input logic a);
    lines = ln;
    ack   = a;
    @(negedge clk);
    ack   = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R10: reset state
    check_all(10, 1'b0, 6'h00, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check_all(10, 1'b0, 6'h00, 64'd0);

    for (int s = 0; s < NSTEP; s++) begin
      step(T_LN[s], T_ACK[s]);
      check_all(T_REQ_ID[s], T_RQ[s], T_VEC[s],
                (s < 7 || s > 9 || T_RQ[s] || 1'b1) ? exp_word0(T_VEC[s]) : 64'd0);
    end

    // R9: acknowledge with slot free is a no-op; raise in same cycle accepted
    step(16'h0040, 1'b1);
    check_all(9, 1'b1, 6'h27, exp_word0(6'h27));
    step(16'h0000, 1'b0);
    check_all(7, 1'b0, 6'h27, exp_word0(6'h27));

    // R8: line 1 and line 12 together, line 1 wins
    step(16'h1002, 1'b0);
    check_all(8, 1'b1, 6'h29, exp_word0(6'h29));
    // R6: line 12 later falls (non-owner) while busy, nothing changes
    step(16'h0002, 1'b0);
    check_all(6, 1'b1, 6'h29, exp_word0(6'h29));

    // R10: reset while busy clears everything
    rst = 1'b1;
    step(16'h0000, 1'b0);
    check_all(10, 1'b0, 6'h00, 64'd0);
    rst = 1'b0;
    step(16'h0000, 1'b0);
    check_all(10, 1'b0, 6'h00, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule